// File: doc/BRIEF.md
# Privileged-Mode Exception Entry Sequencer

This block steers a small processor core into and out of its privileged firmware mode. It picks the handler vector for reset, faults, traps and interrupts. It records the restart address that the handler will return to. It selects which bank of the banked integer registers is visible, and it carries out the return-from-exception path. Decoding instructions and running the handler belong to the surrounding core. The core offers a fault request with a 3-bit class code and the current PC. It can also offer a return command. The sequencer answers one clock later with a registered redirect: the target PC, the PC after it, the saved restart address and pulse flags.

The sequencer is built around one state register with three states. `S_BOOT` lasts for the first cycle after reset. `S_USER` is normal mode. `S_PRIV` is privileged mode with the shadow bank active. The named transitions are BOOT_ENTER (`S_BOOT` to `S_PRIV`, always), TRAP_ENTER (`S_USER` to `S_PRIV` on a fault or an illegal return), TRAP_NEST (`S_PRIV` to `S_PRIV` on a fault), RET_STAY (`S_PRIV` to `S_PRIV` on a return whose saved address has bit 0 set), RET_LEAVE (`S_PRIV` to `S_USER` on a return whose saved address has bit 0 clear) and IDLE (no request, state held).

Integer registers 8 to 14 and 25 have a second, shadow copy that is visible only in privileged mode. Every other register is shared by both modes.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is asserted, `priv_mode` is 1 and `redirect` is 0. On the first clock edge after release, `redirect` pulses and `next_pc` becomes `base_addr + 0x001`. Privileged mode and the shadow bank are active from reset onward.
- R2: A taken fault sets `next_pc` to `base_addr` plus the vector offset of its class code. The codes and offsets are: 0 machine check 0x401, 1 alignment 0x301, 2 interrupt 0x101, 3 software call 0x2001, 4 arithmetic trap 0x501, 5 illegal opcode 0x481, 6 instruction-fetch miss 0x181, 7 data-access miss 0x201. The base value used is the one sampled on the same edge.
- R3: `next_next_pc` always equals `next_pc + 4`.
- R4: On a taken fault, `exc_addr` receives `cur_pc + 4` for codes 3 and 4, and `cur_pc` for every other code.
- R5: An interrupt (code 2) taken while in privileged mode leaves `exc_addr` unchanged.
- R6: Entry from user mode raises `shadow_swap` for one cycle. Entry while already privileged does not.
- R7: Writes and reads of registers 8 to 14 and 25 reach the shadow copy in privileged mode and the normal copy in user mode. All other registers show the same contents in both modes.
- R8: A return command in user mode is rejected. It is handled as an illegal-opcode entry (code 5, `exc_addr = cur_pc`) and `illegal_op` pulses for one cycle.
- R9: A return in privileged mode sets `next_pc` to `exc_addr`. If bit 0 of `exc_addr` is 0 the core leaves privileged mode and `shadow_swap` pulses. If bit 0 is 1 the core stays privileged and there is no swap.
- R10: `intr_recheck` pulses for one cycle after every accepted return and at no other time.
- R11: A fault request takes priority over a return command on the same edge. Both are ignored on the boot edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_req | input | 1 | Fault, trap or interrupt request |
| fault_code | input | 3 | Class code of the request (see R2) |
| cur_pc | input | PC_W | PC of the current instruction |
| eret_req | input | 1 | Return-from-exception command |
| base_addr | input | PC_W | Handler base address |
| rf_wr_en | input | 1 | Register write enable |
| rf_wr_idx | input | IDX_W | Register write index |
| rf_wr_data | input | DATA_W | Register write data |
| rf_rd_idx | input | IDX_W | Register read index |
| rf_rd_data | output | DATA_W | Read data in the current mode's view |
| redirect | output | 1 | One-cycle pulse: `next_pc` holds a new target |
| next_pc | output | PC_W | Redirect target |
| next_next_pc | output | PC_W | Redirect target plus 4 |
| exc_addr | output | PC_W | Saved restart address |
| priv_mode | output | 1 | Privileged mode active |
| shadow_swap | output | 1 | One-cycle pulse when the visible bank changes |
| illegal_op | output | 1 | One-cycle pulse on a rejected return |
| intr_recheck | output | 1 | One-cycle pulse after an accepted return |

## Verification
Every result except register read data is due one cycle after its stimulus. A request sampled on a rising edge updates `redirect`, `next_pc`, `exc_addr`, `priv_mode` and the pulses on that same edge, and those values hold until the next edge. The bench therefore drives inputs on the falling edge, waits for one rising edge and samples on the following falling edge. Register reads are combinational against the current bank, so a write is sampled half a cycle after its edge and a bank change is seen in the cycle after the entry or return that causes it. Pulses are checked in the sampled cycle and again on the next request, where they must be absent.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    typedef enum logic [2:0] {
        FC_MCHK  = 3'd0,
        FC_ALIGN = 3'd1,
        FC_INTR  = 3'd2,
        FC_CALL  = 3'd3,
        FC_ARITH = 3'd4,
        FC_ILLOP = 3'd5,
        FC_IMISS = 3'd6,
        FC_DMISS = 3'd7
    } fault_code_e;

    typedef enum logic [1:0] {
        S_BOOT = 2'd0,
        S_USER = 2'd1,
        S_PRIV = 2'd2
    } mode_state_e;

    localparam logic [15:0] BOOT_OFFSET = 16'h0001;
    localparam int unsigned SHADOW_CNT  = 8;

    function automatic logic [15:0] vec_offset(fault_code_e code);
        logic [15:0] off;
        unique case (code)
            FC_MCHK:  off = 16'h0401;
            FC_ALIGN: off = 16'h0301;
            FC_INTR:  off = 16'h0101;
            FC_CALL:  off = 16'h2001;
            FC_ARITH: off = 16'h0501;
            FC_ILLOP: off = 16'h0481;
            FC_IMISS: off = 16'h0181;
            FC_DMISS: off = 16'h0201;
            default:  off = 16'h0401;
        endcase
        return off;
    endfunction

    // Banked set: registers 8..14 map to slots 0..6, register 25 to slot 7
    function automatic logic is_banked(int unsigned idx);
        return ((idx >= 8) && (idx <= 14)) || (idx == 25);
    endfunction

    function automatic int unsigned bank_slot(int unsigned idx);
        return (idx == 25) ? 7 : (idx - 8);
    endfunction

endpackage

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_seq_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  fault_code_e      code,
    input  logic             in_priv,
    input  logic [PC_W-1:0]  base,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  old_exc,
    output logic [PC_W-1:0]  target,
    output logic [PC_W-1:0]  save_addr
);
    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

    always_comb begin
        target = base + PC_W'(vec_offset(code));
        if (code == FC_INTR && in_priv)
            save_addr = old_exc;
        else if (code == FC_CALL || code == FC_ARITH)
            save_addr = cur_pc + INSN_BYTES;
        else
            save_addr = cur_pc;
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import exc_seq_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shadow_on,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SLOT_W = $clog2(SHADOW_CNT);

    logic [DATA_W-1:0] main_q   [NUM_REGS];
    logic [DATA_W-1:0] shadow_q [SHADOW_CNT];

    logic              wr_to_shadow, rd_from_shadow;
    logic [SLOT_W-1:0] wr_slot, rd_slot;

    always_comb begin
        wr_to_shadow   = shadow_on && is_banked(int'(wr_idx));
        rd_from_shadow = shadow_on && is_banked(int'(rd_idx));
        wr_slot        = SLOT_W'(bank_slot(int'(wr_idx)));
        rd_slot        = SLOT_W'(bank_slot(int'(rd_idx)));
        rd_data        = rd_from_shadow ? shadow_q[rd_slot] : main_q[rd_idx];
    end

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_main
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    main_q[g] <= '0;
                else if (wr_en && !wr_to_shadow && wr_idx == IDX_W'(g))
                    main_q[g] <= wr_data;
            end
        end
        for (g = 0; g < SHADOW_CNT; g++) begin : g_shadow
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    shadow_q[g] <= '0;
                else if (wr_en && wr_to_shadow && wr_slot == SLOT_W'(g))
                    shadow_q[g] <= wr_data;
            end
        end
    endgenerate
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_req,
    input  logic [2:0]        fault_code,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic              eret_req,
    input  logic [PC_W-1:0]   base_addr,
    input  logic              rf_wr_en,
    input  logic [IDX_W-1:0]  rf_wr_idx,
    input  logic [DATA_W-1:0] rf_wr_data,
    input  logic [IDX_W-1:0]  rf_rd_idx,
    output logic [DATA_W-1:0] rf_rd_data,
    output logic              redirect,
    output logic [PC_W-1:0]   next_pc,
    output logic [PC_W-1:0]   next_next_pc,
    output logic [PC_W-1:0]   exc_addr,
    output logic              priv_mode,
    output logic              shadow_swap,
    output logic              illegal_op,
    output logic              intr_recheck
);
    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

    mode_state_e state_q, state_d;
    logic        is_boot, in_priv;
    logic        take_fault, take_illop, take_ret;
    fault_code_e eff_code;
    logic [PC_W-1:0] vec_target, vec_save;

    logic            redirect_q, swap_q, illop_q, recheck_q;
    logic [PC_W-1:0] next_pc_q, exc_q;

    // Request decode
    always_comb begin
        is_boot    = (state_q == S_BOOT);
        in_priv    = (state_q != S_USER);
        take_fault = !is_boot && fault_req;
        take_illop = !is_boot && !fault_req && eret_req && (state_q == S_USER);
        take_ret   = !is_boot && !fault_req && eret_req && (state_q == S_PRIV);
        eff_code   = take_illop ? FC_ILLOP : fault_code_e'(fault_code);
    end

    exc_vector_unit #(.PC_W(PC_W)) u_vec (
        .code      (eff_code),
        .in_priv   (in_priv),
        .base      (base_addr),
        .cur_pc    (cur_pc),
        .old_exc   (exc_q),
        .target    (vec_target),
        .save_addr (vec_save)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_BOOT: state_d = S_PRIV;                                     // BOOT_ENTER
            S_USER: if (take_fault || take_illop) state_d = S_PRIV;       // TRAP_ENTER
            S_PRIV: if (take_ret && !exc_q[0]) state_d = S_USER;          // RET_LEAVE
            default: state_d = S_BOOT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_BOOT;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect_q <= 1'b0;
            next_pc_q  <= '0;
            exc_q      <= '0;
            swap_q     <= 1'b0;
            illop_q    <= 1'b0;
            recheck_q  <= 1'b0;
        end else begin
            redirect_q <= 1'b0;
            swap_q     <= 1'b0;
            illop_q    <= 1'b0;
            recheck_q  <= 1'b0;
            unique case (state_q)
                S_BOOT: begin
                    redirect_q <= 1'b1;
                    next_pc_q  <= base_addr + PC_W'(BOOT_OFFSET);
                end
                S_USER: begin
                    if (take_fault || take_illop) begin
                        redirect_q <= 1'b1;
                        next_pc_q  <= vec_target;
                        exc_q      <= vec_save;
                        swap_q     <= 1'b1;
                        illop_q    <= take_illop;
                    end
                end
                S_PRIV: begin
                    if (take_fault) begin                                 // TRAP_NEST
                        redirect_q <= 1'b1;
                        next_pc_q  <= vec_target;
                        exc_q      <= vec_save;
                    end else if (take_ret) begin                          // RET_STAY / RET_LEAVE
                        redirect_q <= 1'b1;
                        next_pc_q  <= exc_q;
                        swap_q     <= !exc_q[0];
                        recheck_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    banked_regfile #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .shadow_on (in_priv),
        .wr_en     (rf_wr_en),
        .wr_idx    (rf_wr_idx),
        .wr_data   (rf_wr_data),
        .rd_idx    (rf_rd_idx),
        .rd_data   (rf_rd_data)
    );

    assign redirect     = redirect_q;
    assign next_pc      = next_pc_q;
    assign next_next_pc = next_pc_q + INSN_BYTES;
    assign exc_addr     = exc_q;
    assign priv_mode    = in_priv;
    assign shadow_swap  = swap_q;
    assign illegal_op   = illop_q;
    assign intr_recheck = recheck_q;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            is_boot,
    input logic            fault_req,
    input logic [2:0]      fault_code,
    input logic            eret_req,
    input logic            redirect,
    input logic [PC_W-1:0] next_pc,
    input logic [PC_W-1:0] exc_addr,
    input logic            priv_mode,
    input logic            shadow_swap,
    input logic            illegal_op,
    input logic            intr_recheck
);
    // R6
    entry_from_user_swaps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_boot && fault_req && !priv_mode) |=> (redirect && priv_mode && shadow_swap));

    // R6
    nested_entry_no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_boot && fault_req && priv_mode) |=> (redirect && priv_mode && !shadow_swap));

    // R5
    priv_intr_keeps_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_boot && fault_req && fault_code == 3'd2 && priv_mode) |=> $stable(exc_addr));

    // R8
    user_eret_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_boot && !fault_req && eret_req && !priv_mode) |=> (illegal_op && priv_mode && !intr_recheck));

    // R9
    eret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_boot && !fault_req && eret_req && priv_mode) |=> (redirect && next_pc == $past(exc_addr)));

    // R10
    recheck_only_on_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_recheck |-> !illegal_op);
endmodule

bind exc_entry_seq exc_seq_chk #(.PC_W(PC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .is_boot      (is_boot),
    .fault_req    (fault_req),
    .fault_code   (fault_code),
    .eret_req     (eret_req),
    .redirect     (redirect),
    .next_pc      (next_pc),
    .exc_addr     (exc_addr),
    .priv_mode    (priv_mode),
    .shadow_swap  (shadow_swap),
    .illegal_op   (illegal_op),
    .intr_recheck (intr_recheck)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
    localparam int PC_W = 32;
    localparam int DW   = 32;
    localparam int IW   = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fault_req = 1'b0;
    logic [2:0]    fault_code = 3'd0;
    logic [PC_W-1:0] cur_pc = '0;
    logic          eret_req = 1'b0;
    logic [PC_W-1:0] base_addr = 32'h0001_0000;
    logic          rf_wr_en = 1'b0;
    logic [IW-1:0] rf_wr_idx = '0;
    logic [DW-1:0] rf_wr_data = '0;
    logic [IW-1:0] rf_rd_idx = '0;
    logic [DW-1:0] rf_rd_data;
    logic          redirect;
    logic [PC_W-1:0] next_pc, next_next_pc, exc_addr;
    logic          priv_mode, shadow_swap, illegal_op, intr_recheck;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2ns clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .fault_code(fault_code),
        .cur_pc(cur_pc), .eret_req(eret_req), .base_addr(base_addr),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .redirect(redirect),
        .next_pc(next_pc), .next_next_pc(next_next_pc), .exc_addr(exc_addr),
        .priv_mode(priv_mode), .shadow_swap(shadow_swap), .illegal_op(illegal_op),
        .intr_recheck(intr_recheck)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic raise_fault(logic [2:0] code, logic [31:0] pc);
        fault_req = 1'b1; fault_code = code; cur_pc = pc;
        cycle();
        fault_req = 1'b0;
    endtask

    task automatic do_eret(logic [31:0] pc);
        eret_req = 1'b1; cur_pc = pc;
        cycle();
        eret_req = 1'b0;
    endtask

    task automatic wr_reg(int idx, logic [31:0] val);
        rf_wr_en = 1'b1; rf_wr_idx = IW'(idx); rf_wr_data = val;
        cycle();
        rf_wr_en = 1'b0;
    endtask

    task automatic rd_check(string req, int idx, logic [31:0] exp);
        rf_rd_idx = IW'(idx);
        #1ns;
        check(req, rf_rd_data, exp);
    endtask

    task automatic t_reset_boot();
        #5ns;
        check("R1 reset priv", 32'(priv_mode), 1);
        check("R1 reset redirect", 32'(redirect), 0);
        fault_req = 1'b1; fault_code = 3'd0; cur_pc = 32'h100;   // ignored on boot edge (R11)
        @(negedge clk); rst_n = 1'b1;
        cycle();
        fault_req = 1'b0;
        check("R1 boot redirect", 32'(redirect), 1);
        check("R1 boot vector", next_pc, 32'h0001_0001);
        check("R3 boot next-next", next_next_pc, 32'h0001_0005);
        check("R11 boot ignores fault", exc_addr, 32'h0);
        check("R1 priv after boot", 32'(priv_mode), 1);
    endtask

    task automatic t_first_return();
        wr_reg(8, 32'h8888); wr_reg(25, 32'h9999);
        do_eret(32'h0);
        check("R9 ret target", next_pc, 32'h0);
        check("R9 leave priv", 32'(priv_mode), 0);
        check("R9 swap out", 32'(shadow_swap), 1);
        check("R10 recheck", 32'(intr_recheck), 1);
        wr_reg(8, 32'hAAAA); wr_reg(25, 32'h2525); wr_reg(5, 32'h5555);
        wr_reg(15, 32'h1515); wr_reg(14, 32'hEEEE);
        rd_check("R7 user r8", 8, 32'hAAAA);
    endtask

    task automatic t_user_mchk();
        raise_fault(3'd0, 32'h4000);
        check("R2 mchk vector", next_pc, 32'h0001_0401);
        check("R3 next-next", next_next_pc, 32'h0001_0405);
        check("R4 mchk save", exc_addr, 32'h4000);
        check("R6 swap in", 32'(shadow_swap), 1);
        check("R10 no recheck on entry", 32'(intr_recheck), 0);
        rd_check("R7 shadow r8", 8, 32'h8888);
        rd_check("R7 shadow r25", 25, 32'h9999);
        rd_check("R7 shadow r14", 14, 32'h0);
        rd_check("R7 shared r5", 5, 32'h5555);
        rd_check("R7 shared r15", 15, 32'h1515);
    endtask

    task automatic t_priv_intr();
        raise_fault(3'd2, 32'h4101);
        check("R5 exc kept", exc_addr, 32'h4000);
        check("R2 intr vector", next_pc, 32'h0001_0101);
        check("R6 no swap nested", 32'(shadow_swap), 0);
    endtask

    task automatic t_priority_and_stay();
        base_addr = 32'h0002_0000;
        fault_req = 1'b1; fault_code = 3'd1; cur_pc = 32'h5001; eret_req = 1'b1;
        cycle();
        fault_req = 1'b0; eret_req = 1'b0;
        check("R11 fault wins", next_pc, 32'h0002_0301);
        check("R11 no recheck", 32'(intr_recheck), 0);
        check("R4 align save", exc_addr, 32'h5001);
        do_eret(32'h20400);
        check("R9 stay target", next_pc, 32'h5001);
        check("R9 stay priv", 32'(priv_mode), 1);
        check("R9 stay no swap", 32'(shadow_swap), 0);
        check("R10 recheck stay", 32'(intr_recheck), 1);
    endtask

    task automatic t_call_return();
        raise_fault(3'd3, 32'h6000);
        check("R4 call save", exc_addr, 32'h6004);
        check("R2 call vector", next_pc, 32'h0002_2001);
        do_eret(32'h22000);
        check("R9 call ret", next_pc, 32'h6004);
        check("R9 call leave", 32'(priv_mode), 0);
        rd_check("R7 user view back", 8, 32'hAAAA);
    endtask

    task automatic t_illegal_return();
        do_eret(32'h7000);
        check("R8 illegal pulse", 32'(illegal_op), 1);
        check("R8 illegal vector", next_pc, 32'h0002_0481);
        check("R8 illegal save", exc_addr, 32'h7000);
        check("R8 priv", 32'(priv_mode), 1);
        check("R10 no recheck illegal", 32'(intr_recheck), 0);
        do_eret(32'h20500);
        check("R8 pulse cleared", 32'(illegal_op), 0);
    endtask

    task automatic t_arith_and_user_intr();
        raise_fault(3'd4, 32'h7100);
        check("R4 arith save", exc_addr, 32'h7104);
        check("R2 arith vector", next_pc, 32'h0002_0501);
        do_eret(32'h20600);
        raise_fault(3'd2, 32'h8000);
        check("R5 user intr saves", exc_addr, 32'h8000);
        check("R6 user intr swap", 32'(shadow_swap), 1);
        raise_fault(3'd7, 32'h8100);
        check("R2 dmiss vector", next_pc, 32'h0002_0201);
        check("R4 dmiss save", exc_addr, 32'h8100);
    endtask

    initial begin
        #800us;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset_boot();
        t_first_return();
        t_user_mchk();
        t_priv_intr();
        t_priority_and_stay();
        t_call_return();
        t_illegal_return();
        t_arith_and_user_intr();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule